// File: doc/BRIEF.md
# Synchronous Slave Serial Transceiver

This block is a half-duplex serial port that acts only as a slave. An external master supplies the serial clock, and that clock moves every data bit. No local clock is needed to shift a word, so the port keeps receiving or transmitting while the host clock is gated off. One data pin carries traffic in both directions. A direction bit decides whether the port listens on that pin or drives it.

Toward the host, the block has a two-register interface. The data register returns the last received word when read. Writing it loads a transmit holding register, which feeds a transmit shift register. Status bits report a received word waiting, the holding register free, and a sticky overrun. Each of the two interrupt outputs is gated by its own enable bit and by a shared peripheral enable bit. All flags cross into the host clock domain through synchronizer chains, and the host-side acknowledges cross back as toggles.

Word format: `WORD_W` bits, least significant bit first. The clock idles high. The port drives the pin on each falling clock edge and samples it on each rising edge.

Top module: `sync_slave_xcvr`

## Requirements
- R1: In receive mode (control bit 3 = 0), the block captures `dat_in` on each rising `sclk` edge, least significant bit first. After eight edges, reading the data register (`reg_sel` = 0) returns the word. This holds even when `clk` is stopped while the bits arrive.
- R2: Status bit 4 becomes 1 after a complete word is received. A read of the data register with `reg_rd` = 1 clears it.
- R3: If a word completes while status bit 4 is still 1, the new word is discarded and status bit 6 is set. Bit 6 stays set until a control write with bit 7 = 1.
- R4: In transmit mode (control bit 3 = 1), a written byte moves from the holding register into the shift register on the next falling `sclk` edge. Its bits are driven on `dat_out`, least significant bit first, one per falling edge, with `dat_oe` = 1.
- R5: Status bit 5 (holding register free) reads 1 after reset. A write to the data register clears it. It returns to 1 when the held byte moves into the shift register.
- R6: If a byte is pending when a word's last bit has been clocked out, the next falling edge starts that byte with no idle bit in between.
- R7: A data-register write while status bit 5 is 0 is ignored.
- R8: `dat_oe` falls to 0 on the falling edge that ends a word when no byte is pending.
- R9: `rx_irq` equals status bit 4 AND control bit 0 AND control bit 2. `tx_irq` equals status bit 5 AND control bit 1 AND control bit 2.
- R10: In transmit mode, `sclk` edges do not receive data. In receive mode, a pending byte is never driven. It is sent once transmit mode is selected.
- R11: After reset, the control register reads back 0x20 (only status bit 5 set), and `dat_oe`, `rx_irq` and `tx_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host register clock; may be stopped |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sclk | input | 1 | Serial clock from the external master, idle high |
| dat_in | input | 1 | Data pin input path |
| dat_out | output | 1 | Data pin output value |
| dat_oe | output | 1 | Data pin output enable |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the received word) |
| reg_sel | input | 1 | 0 = data register, 1 = control/status register |
| reg_wdata | input | WORD_W | Write data |
| reg_rdata | output | WORD_W | Read data for the register chosen by `reg_sel` |
| rx_irq | output | 1 | Gated received-word interrupt / wake |
| tx_irq | output | 1 | Gated holding-register-free interrupt / wake |

## Verification
The bench uses the defaults: `WORD_W` = 8 and `SYNC_STAGES` = 2. With an 8-bit word, every bit pattern is easy to compare, and the sclk cycles needed to fill, overrun and refill the receive buffer stay short. Two synchronizer stages keep the flag latency at a few host cycles. That leaves room to stop the host clock during a whole received word, and to write the second transmit byte while the first is still shifting.

// File: rtl/sxcvr_pkg.sv
package sxcvr_pkg;
    // control / status register bit positions
    localparam int unsigned CTL_RXIE   = 0;
    localparam int unsigned CTL_TXIE   = 1;
    localparam int unsigned CTL_PIE    = 2;
    localparam int unsigned CTL_DIR    = 3;
    localparam int unsigned ST_RXFULL  = 4;
    localparam int unsigned ST_TXFREE  = 5;
    localparam int unsigned ST_OVR     = 6;
    localparam int unsigned CTL_OVRCLR = 7;

    typedef enum logic {
        REG_DATA = 1'b0,
        REG_CTRL = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/sxcvr_sync.sv
module sxcvr_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < int'(STAGES); i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/sxcvr_rx.sv
module sxcvr_rx #(
    parameter int unsigned WORD_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              din,
    input  logic              take_tgl,
    output logic [WORD_W-1:0] buf_data,
    output logic              put_tgl,
    output logic              ovr_tgl
);
    localparam int unsigned CNT_W = $clog2(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] buffer;
        logic              put;
        logic              ovr;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   take_s;
    logic [WORD_W-1:0] word;

    sxcvr_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_take_sync (
        .clk(sclk), .rst_n(rst_n), .d(take_tgl), .q(take_s)
    );

    always_comb begin
        st_d = st_q;
        word = {din, st_q.sr[WORD_W-1:1]};
        if (rx_en) begin
            st_d.sr = word;
            if (st_q.cnt == CNT_W'(WORD_W - 1)) begin
                st_d.cnt = '0;
                if (st_q.put != take_s) begin
                    st_d.ovr = ~st_q.ovr;          // buffer unread: drop word
                end else begin
                    st_d.buffer = word;
                    st_d.put    = ~st_q.put;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign buf_data = st_q.buffer;
    assign put_tgl  = st_q.put;
    assign ovr_tgl  = st_q.ovr;
endmodule

// File: rtl/sxcvr_tx.sv
module sxcvr_tx #(
    parameter int unsigned WORD_W = 8
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic [WORD_W-1:0] hold_data,
    input  logic              hold_put,
    output logic              dout,
    output logic              oe,
    output logic              take_tgl
);
    localparam int unsigned CNT_W = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] tsr;
        logic [CNT_W-1:0]  cnt;
        logic              take;
        logic              oe;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!tx_en) begin
            st_d.cnt = '0;
            st_d.oe  = 1'b0;
        end else if (st_q.cnt == '0 || st_q.cnt == CNT_W'(WORD_W)) begin
            if (hold_put != st_q.take) begin
                st_d.tsr  = hold_data;
                st_d.cnt  = CNT_W'(1);
                st_d.take = ~st_q.take;
                st_d.oe   = 1'b1;
            end else begin
                st_d.cnt = '0;
                st_d.oe  = 1'b0;
            end
        end else begin
            st_d.tsr = st_q.tsr >> 1;
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(negedge sclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout     = st_q.tsr[0];
    assign oe       = st_q.oe;
    assign take_tgl = st_q.take;
endmodule

// File: rtl/sync_slave_xcvr.sv
module sync_slave_xcvr
    import sxcvr_pkg::*;
#(
    parameter int unsigned WORD_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              dat_in,
    output logic              dat_out,
    output logic              dat_oe,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              rx_irq,
    output logic              tx_irq
);
    typedef struct packed {
        logic              rx_ie;
        logic              tx_ie;
        logic              pie;
        logic              dir_tx;
        logic              rx_take;
        logic              hold_put;
        logic [WORD_W-1:0] hold;
        logic              ovr;
        logic              ovr_seen;
    } sys_st_t;

    sys_st_t sys_d, sys_q;

    logic [WORD_W-1:0] rx_buf;
    logic rx_put, rx_ovr_tgl, tx_take;
    logic rx_put_s, rx_ovr_s, tx_take_s;
    logic rx_full, tx_free, ovr_flag, pie_en, dir_tx;

    sxcvr_rx #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .sclk(sclk), .rst_n(rst_n), .rx_en(!sys_q.dir_tx), .din(dat_in),
        .take_tgl(sys_q.rx_take), .buf_data(rx_buf), .put_tgl(rx_put),
        .ovr_tgl(rx_ovr_tgl)
    );

    sxcvr_tx #(.WORD_W(WORD_W)) u_tx (
        .sclk(sclk), .rst_n(rst_n), .tx_en(sys_q.dir_tx),
        .hold_data(sys_q.hold), .hold_put(sys_q.hold_put),
        .dout(dat_out), .oe(dat_oe), .take_tgl(tx_take)
    );

    sxcvr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_flag_sync (
        .clk(clk), .rst_n(rst_n),
        .d({rx_put, rx_ovr_tgl, tx_take}),
        .q({rx_put_s, rx_ovr_s, tx_take_s})
    );

    assign rx_full  = rx_put_s != sys_q.rx_take;
    assign tx_free  = tx_take_s == sys_q.hold_put;
    assign ovr_flag = sys_q.ovr;
    assign pie_en   = sys_q.pie;
    assign dir_tx   = sys_q.dir_tx;

    always_comb begin
        sys_d = sys_q;
        sys_d.ovr_seen = rx_ovr_s;
        if (reg_wr && reg_sel == REG_CTRL) begin
            sys_d.rx_ie  = reg_wdata[CTL_RXIE];
            sys_d.tx_ie  = reg_wdata[CTL_TXIE];
            sys_d.pie    = reg_wdata[CTL_PIE];
            sys_d.dir_tx = reg_wdata[CTL_DIR];
            if (reg_wdata[CTL_OVRCLR]) sys_d.ovr = 1'b0;
        end
        if (rx_ovr_s != sys_q.ovr_seen) sys_d.ovr = 1'b1;   // set wins over clear
        if (reg_wr && reg_sel == REG_DATA && tx_free) begin
            sys_d.hold     = reg_wdata;
            sys_d.hold_put = ~sys_q.hold_put;
        end
        if (reg_rd && reg_sel == REG_DATA && rx_full) begin
            sys_d.rx_take = ~sys_q.rx_take;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sys_q <= '0;
        else        sys_q <= sys_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel == REG_CTRL) begin
            reg_rdata[CTL_RXIE]  = sys_q.rx_ie;
            reg_rdata[CTL_TXIE]  = sys_q.tx_ie;
            reg_rdata[CTL_PIE]   = sys_q.pie;
            reg_rdata[CTL_DIR]   = sys_q.dir_tx;
            reg_rdata[ST_RXFULL] = rx_full;
            reg_rdata[ST_TXFREE] = tx_free;
            reg_rdata[ST_OVR]    = sys_q.ovr;
        end else begin
            reg_rdata = rx_buf;
        end
    end

    assign rx_irq = rx_full & sys_q.rx_ie & sys_q.pie;
    assign tx_irq = tx_free & sys_q.tx_ie & sys_q.pie;
endmodule

// File: rtl/sxcvr_chk.sv
module sxcvr_chk
    import sxcvr_pkg::*;
#(
    parameter int unsigned WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic              reg_sel,
    input logic [WORD_W-1:0] reg_wdata,
    input logic              rx_full,
    input logic              tx_free,
    input logic              ovr_flag,
    input logic              pie_en,
    input logic              rx_irq,
    input logic              tx_irq,
    input logic [WORD_W-1:0] rx_buf
);
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !pie_en |-> (!rx_irq && !tx_irq)); // R9

    AST_RX_POP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == REG_DATA && rx_full) |=> !rx_full); // R2

    AST_TX_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == REG_DATA && tx_free) |=> !tx_free); // R5

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !(reg_wr && reg_sel == REG_CTRL && reg_wdata[CTL_OVRCLR])) |=> ovr_flag); // R3

    AST_RX_BUF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |=> (!rx_full || $stable(rx_buf))); // R1
endmodule

bind sync_slave_xcvr sxcvr_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .rx_full(rx_full),
    .tx_free(tx_free), .ovr_flag(ovr_flag), .pie_en(pie_en),
    .rx_irq(rx_irq), .tx_irq(tx_irq), .rx_buf(rx_buf)
);

// File: tb/tb_sync_slave_xcvr.sv
module tb_sync_slave_xcvr;
    localparam int W = 8;

    logic clk = 1'b0, clk_run = 1'b1, rst_n = 1'b0;
    logic sclk = 1'b1, dat_in = 1'b0;
    logic dat_out, dat_oe, rx_irq, tx_irq;
    logic reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
    logic [W-1:0] reg_wdata = '0, reg_rdata;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = clk_run ? ~clk : clk;

    sync_slave_xcvr #(.WORD_W(W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .dat_in(dat_in),
        .dat_out(dat_out), .dat_oe(dat_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [W-1:0] d);
        @(negedge clk); reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic sel, input logic pop, output logic [W-1:0] d);
        @(negedge clk); reg_sel = sel; reg_rd = pop; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic master_send(input logic [W-1:0] b);
        for (int i = 0; i < W; i++) begin
            sclk = 1'b0; dat_in = b[i]; #20;
            sclk = 1'b1; #20;
        end
    endtask

    task automatic master_recv(output logic [W-1:0] b, output logic oe0);
        for (int i = 0; i < W; i++) begin
            sclk = 1'b0; #19;
            b[i] = dat_out;
            if (i == 0) oe0 = dat_oe;
            #1 sclk = 1'b1; #20;
        end
    endtask

    task automatic end_edge(input string tag);
        sclk = 1'b0; #20;
        chk(tag, dat_oe, 0);
        sclk = 1'b1; #20;
    endtask

    task automatic t_reset();
        logic [W-1:0] s;
        reg_read(1'b1, 1'b0, s);
        chk("R11 ctrl after reset", s, 8'h20);
        chk("R11 dat_oe after reset", dat_oe, 0);
        chk("R11 rx_irq after reset", rx_irq, 0);
        chk("R11 tx_irq after reset", tx_irq, 0);
    endtask

    task automatic t_rx_basic();
        logic [W-1:0] s;
        reg_write(1'b1, 8'h05);
        @(negedge clk); clk_run = 1'b0;          // host clock stopped
        master_send(8'hA5);
        #12 clk_run = 1'b1;
        settle();
        reg_read(1'b1, 1'b0, s);
        chk("R2 rx flag set", s[4], 1);
        chk("R9 rx_irq enabled", rx_irq, 1);
        reg_read(1'b0, 1'b1, s);
        chk("R1 word with clock stopped", s, 8'hA5);
        settle();
        reg_read(1'b1, 1'b0, s);
        chk("R2 rx flag cleared by read", s[4], 0);
        chk("R9 rx_irq low when empty", rx_irq, 0);
        master_send(8'h3C);
        settle();
        reg_write(1'b1, 8'h01);
        @(negedge clk);
        chk("R9 rx_irq blocked without common enable", rx_irq, 0);
        reg_write(1'b1, 8'h07);
        @(negedge clk);
        chk("R9 rx_irq with both enables", rx_irq, 1);
        chk("R9 tx_irq with both enables", tx_irq, 1);
        reg_read(1'b0, 1'b1, s);
        chk("R1 second word", s, 8'h3C);
        reg_write(1'b1, 8'h00);
    endtask

    task automatic t_overrun();
        logic [W-1:0] s;
        master_send(8'h11);
        master_send(8'h22);
        settle();
        reg_read(1'b1, 1'b0, s);
        chk("R3 overrun set", s[6], 1);
        reg_read(1'b0, 1'b1, s);
        chk("R3 first word kept", s, 8'h11);
        settle();
        reg_read(1'b1, 1'b0, s);
        chk("R3 overrun sticky after read", s[6], 1);
        reg_write(1'b1, 8'h80);
        reg_read(1'b1, 1'b0, s);
        chk("R3 overrun cleared", s[6], 0);
        master_send(8'h33);
        settle();
        reg_read(1'b0, 1'b1, s);
        chk("R3 reception resumes", s, 8'h33);
        settle();
    endtask

    task automatic t_tx();
        logic [W-1:0] s, g1, g2;
        logic oe1, oe2;
        reg_write(1'b1, 8'h08);
        reg_write(1'b0, 8'h96);
        reg_read(1'b1, 1'b0, s);
        chk("R5 free flag cleared by write", s[5], 0);
        reg_write(1'b0, 8'h55);                 // must be ignored
        master_recv(g1, oe1);
        chk("R4 transmitted word", g1, 8'h96);
        chk("R4 dat_oe while shifting", oe1, 1);
        settle();
        reg_read(1'b1, 1'b0, s);
        chk("R5 free flag set after load", s[5], 1);
        end_edge("R7 R8 released, ignored byte not sent");
        reg_write(1'b0, 8'hC3);
        fork
            master_recv(g1, oe1);
            begin
                #60; settle();
                reg_read(1'b1, 1'b0, s);
                chk("R5 free while first word shifts", s[5], 1);
                reg_write(1'b0, 8'h3E);
            end
        join
        master_recv(g2, oe2);
        chk("R6 first of pair", g1, 8'hC3);
        chk("R6 second of pair", g2, 8'h3E);
        chk("R6 no gap between words", oe2, 1);
        end_edge("R8 release after pair");
    endtask

    task automatic t_dir();
        logic [W-1:0] s, g;
        logic oe1;
        master_send(8'h5A);                     // still in transmit mode
        settle();
        reg_read(1'b1, 1'b0, s);
        chk("R10 no receive in transmit mode", s[4], 0);
        reg_write(1'b1, 8'h00);
        reg_write(1'b0, 8'h77);
        master_send(8'h00);
        chk("R10 no drive in receive mode", dat_oe, 0);
        settle();
        reg_read(1'b1, 1'b0, s);
        chk("R10 byte still pending", s[5], 0);
        reg_read(1'b0, 1'b1, s);
        chk("R10 receive mode word", s, 8'h00);
        reg_write(1'b1, 8'h08);
        master_recv(g, oe1);
        chk("R10 pending byte sent in transmit mode", g, 8'h77);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_rx_basic();
        t_overrun();
        t_tx();
        t_dir();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule